// File: doc/BRIEF.md
# Sleep Mode Controller

This block sits beside a small processor core and owns its two sleep depths. Software writes a mode word carrying two request bits, a light-sleep bit and a deep-sleep bit. In light sleep the processor clock enable drops while the peripheral clock and the oscillator keep running, so timers, the serial unit and interrupt logic stay alive. In deep sleep the oscillator enable drops as well, and every clock stops.

The exits differ by depth. Light sleep ends on any enabled interrupt, and the block then pulses a one-cycle wake indication. It also ends on a hardware reset. In that case the processor clock comes back for a fixed window of machine cycles before the core reset is raised. During that window writes to RAM are blocked, but other writes such as port writes are not. Deep sleep ignores interrupts completely. Only a hardware reset ends it, and that reset goes straight into core reset with the oscillator re-enabled, leaving RAM contents alone.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After the asynchronous reset is released, the block is in the running state. All three clock enables are 1. The RAM-write inhibit, core reset, wake, light-sleep flag and deep-sleep flag are all 0.
- R2: In the running state, a mode write with the deep-sleep bit set enters deep sleep on the next cycle, whatever the light-sleep bit holds. A mode write with only the light-sleep bit set enters light sleep.
- R3: In light sleep, the processor clock enable is 0 and the peripheral clock and oscillator enables are 1.
- R4: In deep sleep, the processor clock, peripheral clock and oscillator enables are all 0.
- R5: In deep sleep, interrupts have no effect and the block stays in deep sleep. A hardware reset moves it to core reset on the next cycle, with the oscillator enable at 1 and no RAM-write inhibit window.
- R6: An interrupt in light sleep without hardware reset returns the block to running on the next cycle. The light-sleep flag clears and wake is 1 for exactly one cycle. An interrupt in the running state gives no wake.
- R7: A hardware reset in light sleep takes priority over an interrupt. For exactly MC_CYCLES*WIN_MC cycles (24 by default) the processor clock enable is 1 and the RAM-write inhibit is 1. After that the core reset is 1, with the inhibit at 0, until the hardware reset falls.
- R8: A hardware reset in the running state raises core reset on the next cycle. Once the hardware reset is 0, the block returns to running on the next cycle.
- R9: A mode write with both request bits 0 leaves the running state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_idle | input | 1 | Light-sleep request bit of the mode word |
| mode_pdown | input | 1 | Deep-sleep request bit of the mode word |
| irq_any | input | 1 | At least one enabled interrupt pending |
| hw_rst | input | 1 | Synchronized hardware reset, active high |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks RAM writes during the reset window |
| core_rst | output | 1 | Internal core reset |
| wake | output | 1 | One-cycle pulse on interrupt wake |
| idle_flag | output | 1 | Light-sleep state flag |
| pdown_flag | output | 1 | Deep-sleep state flag |

## Verification
The bench drives both request bits together to check that deep sleep wins. A priority bug would land in light sleep with the oscillator still running. It keeps interrupts asserted through deep sleep, where a faulty design would wake with its clocks off. It fires an interrupt and a hardware reset in the same cycle during light sleep and counts the inhibit cycles. A wrong priority shows up as a spurious wake pulse, and an off-by-one counter shows up as 23 or 25 inhibit cycles. Long random runs compare every output every cycle against a bench model, which also catches a wake pulse that lasts longer than one cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    LP_RUN     = 3'd0,
    LP_IDLE    = 3'd1,
    LP_PDOWN   = 3'd2,
    LP_RSTWIN  = 3'd3,
    LP_CORERST = 3'd4
  } lp_state_e;
endpackage

// File: rtl/lp_win_timer.sv
module lp_win_timer #(
  parameter int unsigned WIN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (run_i) cnt_d = cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_wr,
  input  logic      mode_idle,
  input  logic      mode_pdown,
  input  logic      irq_any,
  input  logic      hw_rst,
  input  logic      win_done,
  output lp_state_e state_o,
  output logic      wake_o
);
  lp_state_e st_q, st_d;
  logic      wake_q, wake_d;

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    unique case (st_q)
      LP_RUN: begin
        if (hw_rst)                       st_d = LP_CORERST;
        else if (mode_wr && mode_pdown)   st_d = LP_PDOWN;
        else if (mode_wr && mode_idle)    st_d = LP_IDLE;
      end
      LP_IDLE: begin
        if (hw_rst) st_d = LP_RSTWIN;
        else if (irq_any) begin
          st_d   = LP_RUN;
          wake_d = 1'b1;
        end
      end
      LP_PDOWN:   if (hw_rst)   st_d = LP_CORERST;
      LP_RSTWIN:  if (win_done) st_d = LP_CORERST;
      LP_CORERST: if (!hw_rst)  st_d = LP_RUN;
      default:                  st_d = LP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LP_RUN;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
    end
  end

  assign state_o = st_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/lp_out_decode.sv
module lp_out_decode
  import lp_pkg::*;
(
  input  lp_state_e state_i,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en,
  output logic      ram_wr_inhibit,
  output logic      core_rst,
  output logic      idle_flag,
  output logic      pdown_flag
);
  always_comb begin
    idle_flag      = (state_i == LP_IDLE);
    pdown_flag     = (state_i == LP_PDOWN);
    cpu_clk_en     = !(idle_flag || pdown_flag);
    per_clk_en     = !pdown_flag;
    osc_en         = !pdown_flag;
    ram_wr_inhibit = (state_i == LP_RSTWIN);
    core_rst       = (state_i == LP_CORERST);
  end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned MC_CYCLES = 12,
  parameter int unsigned WIN_MC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic mode_idle,
  input  logic mode_pdown,
  input  logic irq_any,
  input  logic hw_rst,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic ram_wr_inhibit,
  output logic core_rst,
  output logic wake,
  output logic idle_flag,
  output logic pdown_flag
);
  localparam int unsigned WIN = MC_CYCLES * WIN_MC;

  logic [1:0] rsync_q;
  logic       rst_s;
  lp_state_e  state;
  logic       win_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  lp_win_timer #(.WIN(WIN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s),
    .run_i  (state == LP_RSTWIN),
    .done_o (win_done)
  );

  lp_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .mode_wr    (mode_wr),
    .mode_idle  (mode_idle),
    .mode_pdown (mode_pdown),
    .irq_any    (irq_any),
    .hw_rst     (hw_rst),
    .win_done   (win_done),
    .state_o    (state),
    .wake_o     (wake)
  );

  lp_out_decode u_dec (
    .state_i        (state),
    .cpu_clk_en     (cpu_clk_en),
    .per_clk_en     (per_clk_en),
    .osc_en         (osc_en),
    .ram_wr_inhibit (ram_wr_inhibit),
    .core_rst       (core_rst),
    .idle_flag      (idle_flag),
    .pdown_flag     (pdown_flag)
  );
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_wr,
  input logic mode_pdown,
  input logic irq_any,
  input logic hw_rst,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_en,
  input logic ram_wr_inhibit,
  input logic core_rst,
  input logic wake,
  input logic idle_flag,
  input logic pdown_flag
);
  logic running;
  assign running = cpu_clk_en && !core_rst && !ram_wr_inhibit;

  p_pd_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && mode_wr && mode_pdown && !hw_rst |=> pdown_flag);

  p_idle_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> (!cpu_clk_en && per_clk_en && osc_en));

  p_pd_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_flag |-> (!cpu_clk_en && !per_clk_en && !osc_en));

  p_pd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_flag && !hw_rst |=> pdown_flag && !wake);

  p_pd_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_flag && hw_rst |=> core_rst && osc_en && !ram_wr_inhibit);

  p_wake_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_idle_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag && irq_any && !hw_rst |=> wake && !idle_flag && cpu_clk_en);

  p_win_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_inhibit) |-> $past(idle_flag));

  p_idle_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag && hw_rst |=> ram_wr_inhibit && cpu_clk_en && !wake);

  p_run_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && hw_rst |=> core_rst);
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_s),
  .mode_wr        (mode_wr),
  .mode_pdown     (mode_pdown),
  .irq_any        (irq_any),
  .hw_rst         (hw_rst),
  .cpu_clk_en     (cpu_clk_en),
  .per_clk_en     (per_clk_en),
  .osc_en         (osc_en),
  .ram_wr_inhibit (ram_wr_inhibit),
  .core_rst       (core_rst),
  .wake           (wake),
  .idle_flag      (idle_flag),
  .pdown_flag     (pdown_flag)
);

// File: tb/tb_lp_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lp_mode_ctrl;
  localparam int WIN = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, mode_idle = 0, mode_pdown = 0, irq_any = 0, hw_rst = 0;
  logic cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit, core_rst, wake;
  logic idle_flag, pdown_flag;

  always #10 clk = ~clk;

  lp_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_idle(mode_idle),
    .mode_pdown(mode_pdown), .irq_any(irq_any), .hw_rst(hw_rst),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ram_wr_inhibit(ram_wr_inhibit), .core_rst(core_rst), .wake(wake),
    .idle_flag(idle_flag), .pdown_flag(pdown_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  // model: 0 run, 1 light sleep, 2 deep sleep, 3 reset window, 4 core reset
  int m_st = 0, m_cnt = 0;
  bit m_wake = 0;

  function automatic logic [7:0] exp_vec(int st, bit wk);
    logic cpu, per, osc;
    cpu = !(st == 1 || st == 2);
    per = (st != 2);
    osc = (st != 2);
    return {cpu, per, osc, logic'(st == 3), logic'(st == 4), wk,
            logic'(st == 1), logic'(st == 2)};
  endfunction

  function automatic logic [7:0] got_vec();
    return {cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit, core_rst, wake,
            idle_flag, pdown_flag};
  endfunction

  task automatic check(string t, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", t, got, exp);
    end
  endtask

  task automatic model_step();
    bit nw;
    nw = 0;
    case (m_st)
      0: if (hw_rst) m_st = 4;
         else if (mode_wr && mode_pdown) m_st = 2;
         else if (mode_wr && mode_idle) m_st = 1;
      1: if (hw_rst) begin m_st = 3; m_cnt = 0; end
         else if (irq_any) begin m_st = 0; nw = 1; end
      2: if (hw_rst) m_st = 4;
      3: if (m_cnt == WIN - 1) m_st = 4; else m_cnt++;
      default: if (!hw_rst) m_st = 0;
    endcase
    m_wake = nw;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, got_vec(), exp_vec(m_st, m_wake));
  endtask

  task automatic drive(bit wr, bit id, bit pd, bit irq, bit hr);
    mode_wr = wr; mode_idle = id; mode_pdown = pd; irq_any = irq; hw_rst = hr;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    if (!finished) $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int inh_cnt;
    #45 rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: state after reset
    check("R1", got_vec(), 8'b11100000);
    tag = "R1"; tick();

    // R9: empty mode write
    tag = "R9"; drive(1, 0, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
    check("R9", got_vec(), 8'b11100000);

    // R2: both bits -> deep sleep
    tag = "R2"; drive(1, 1, 1, 0, 0); tick();
    check("R2", got_vec(), 8'b00000001);
    tag = "R4"; drive(0, 0, 0, 0, 0); repeat (3) tick();
    // R5: interrupts ignored, reset exits to core reset
    tag = "R5"; drive(0, 0, 0, 1, 0); repeat (6) tick();
    check("R5", got_vec(), 8'b00000001);
    drive(0, 0, 0, 1, 1); tick();
    check("R5", got_vec(), 8'b11101000);
    drive(0, 0, 0, 0, 1); repeat (2) tick();
    drive(0, 0, 0, 0, 0); tick();

    // R2/R3: light sleep, R6: interrupt wake
    tag = "R2"; drive(1, 1, 0, 0, 0); tick();
    check("R2", got_vec(), 8'b01100010);
    tag = "R3"; drive(0, 0, 0, 0, 0); repeat (3) tick();
    tag = "R6"; drive(0, 0, 0, 1, 0); tick();
    check("R6", got_vec(), 8'b11100100);
    drive(0, 0, 0, 1, 0); tick();
    check("R6", got_vec(), 8'b11100000);
    drive(0, 0, 0, 0, 0); tick();

    // R7: reset with interrupt in light sleep -> inhibit window
    tag = "R7"; drive(1, 1, 0, 0, 0); tick();
    drive(0, 0, 0, 1, 1); tick();
    check("R7", got_vec(), 8'b11110000);
    inh_cnt = 1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (ram_wr_inhibit) inh_cnt++;
    end
    n_chk++;
    if (inh_cnt != WIN) begin
      n_fail++;
      $display("FAIL R7: inhibit cycles %0d expected %0d", inh_cnt, WIN);
    end
    check("R7", got_vec(), 8'b11101000);
    drive(0, 0, 0, 0, 0); tick();

    // R8: reset while running
    tag = "R8"; drive(0, 0, 0, 0, 1); tick();
    check("R8", got_vec(), 8'b11101000);
    drive(0, 0, 0, 0, 0); tick();
    check("R8", got_vec(), 8'b11100000);

    // random mix
    tag = "random";
    void'($urandom(32'h1d5a));
    for (int i = 0; i < 6000; i++) begin
      drive(($urandom % 6) == 0, $urandom % 2, ($urandom % 3) == 0,
            ($urandom % 4) == 0, ($urandom % 20) == 0);
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule